// File: doc/BRIEF.md
# Strided Two-Dimensional DMA Address Generator

This block is the address engine of one channel in a strided 2-D DMA engine. Software loads a start word address, a line length, a line stride and a line count, then pulses `start`. From the cycle after that pulse, the channel walks a word address through a frame of lines. Within a line the address rises by one word per transfer. Each new line begins one stride after the start of the previous line, so the gap between lines is skipped. All lengths are in 32-bit words, and the address is a word address, which is the byte address shifted right by two. `req_addr` always shows the live address, so the remaining byte count can be derived from it at any time.

The addresses leave the block as a valid/ready stream. `req_valid` rises when a transfer is launched. Once `req_valid` is high, the address holds steady until the memory side accepts it with `req_ready`. Each accepted beat moves exactly one word, and `req_ready` may be held low for any number of cycles without losing a word.

A line length of zero selects ring mode. In ring mode the channel cycles through a region of stride × (line count + 1) words and wraps back to the start address. It raises `half_a` at the end of the first half and `half_b` at the end of the second half, on every pass. Ring mode continues until `loop_en` is cleared. A synchronous `invalidate` aborts the channel in either mode.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the channel is idle: `req_valid`, `done`, `half_a` and `half_b` are all 0.
- R2: A `start` pulse while idle makes `req_valid` go high on the following cycle with `req_addr` equal to `cfg_start_addr`. A `start` while the channel is busy is ignored and does not disturb the address.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` does not change.
- R4: Within a line, each accepted beat advances `req_addr` by one word. A line holds `cfg_line_len` words.
- R5: After the last word of a line, the next address is that line's first address plus `cfg_stride`.
- R6: `cfg_line_cnt` holds the number of lines minus one, so 0 means one line. When the last word of the last line is accepted, `done` is high for exactly one cycle. The channel then goes idle and `req_addr` keeps the final word address.
- R7: With `cfg_line_len` = 0 the channel runs in ring mode. It visits `start` through `start + S - 1`, where S = `cfg_stride` × (`cfg_line_cnt` + 1), and then returns to `start`. S must be even and at least 2.
- R8: In ring mode, `half_a` pulses for one cycle after the word at offset S/2 - 1 is accepted. `half_b` pulses for one cycle after the word at offset S - 1 is accepted. Both pulses repeat on every pass.
- R9: In ring mode, if `loop_en` is low when a beat is accepted, the channel goes idle after that word and does not raise `done`.
- R10: `mem_read` and `burst4` take `cfg_dir` and `cfg_burst` at launch and stay constant for the whole transfer. `cfg_dir` = 1 means memory to device, so memory is read. `cfg_burst` = 1 selects 4-word bursts.
- R11: `invalidate` takes priority over everything else. One cycle later the channel is idle with no `done` or half pulse, and a `start` in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_addr | input | ADDR_W | Start word address, sampled at launch |
| cfg_line_len | input | LEN_W | Words per line; 0 selects ring mode |
| cfg_stride | input | LEN_W | Words from one line start to the next |
| cfg_line_cnt | input | CNT_W | Number of lines minus one |
| cfg_dir | input | 1 | 1 = memory to device, 0 = device to memory |
| cfg_burst | input | 1 | 1 = 4-word burst mode |
| loop_en | input | 1 | Keeps ring mode running while high |
| start | input | 1 | Launch strobe, the final step of programming |
| invalidate | input | 1 | Synchronous abort |
| req_valid | output | 1 | Address stream valid |
| req_ready | input | 1 | Address stream ready, one word per beat |
| req_addr | output | ADDR_W | Live current word address |
| mem_read | output | 1 | Latched direction: memory is read |
| burst4 | output | 1 | Latched burst mode |
| done | output | 1 | One-cycle end-of-frame pulse |
| half_a | output | 1 | One-cycle end-of-first-half pulse (ring mode) |
| half_b | output | 1 | One-cycle end-of-second-half pulse (ring mode) |

## Verification
Every result of this block arrives exactly one clock edge after its cause. `req_valid` and the start address appear one edge after `start`. A new address appears one edge after the beat that accepted the previous one. `done`, `half_a` and `half_b` are due one edge after the accepting beat, and idle is due one edge after `invalidate`. The bench changes inputs only on falling edges and reads outputs on the following falling edge. Each expected pulse is therefore checked against the word accepted in the previous half-period pair. When `req_ready` is held low, the bench expects the same address again on the next sample.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_FRAME = 2'd1,
    CH_RING  = 2'd2
  } ch_state_e;

  typedef struct packed {
    logic line_end;
    logic frame_end;
  } line_flags_t;

  typedef struct packed {
    logic half_end;
    logic wrap;
  } ring_flags_t;

endpackage

// File: rtl/dma2d_line_walk.sv
module dma2d_line_walk
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              active,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [LEN_W-1:0]  ld_stride,
  input  logic [CNT_W-1:0]  ld_lines,
  output line_flags_t       flags,
  output logic [ADDR_W-1:0] next_line_addr
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  stride_q;
  logic [CNT_W-1:0]  lines_q;
  logic [LEN_W-1:0]  x_cnt;
  logic [CNT_W-1:0]  y_cnt;
  logic [ADDR_W-1:0] line_base;

  assign flags.line_end  = (x_cnt == len_q - LEN_ONE);
  assign flags.frame_end = (y_cnt == lines_q);
  assign next_line_addr  = line_base + ADDR_W'(stride_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q     <= '0;
      stride_q  <= '0;
      lines_q   <= '0;
      x_cnt     <= '0;
      y_cnt     <= '0;
      line_base <= '0;
    end else if (load) begin
      len_q     <= ld_len;
      stride_q  <= ld_stride;
      lines_q   <= ld_lines;
      x_cnt     <= '0;
      y_cnt     <= '0;
      line_base <= ld_addr;
    end else if (step) begin
      if (flags.line_end) begin
        x_cnt     <= '0;
        y_cnt     <= y_cnt + CNT_ONE;
        line_base <= next_line_addr;
      end else begin
        x_cnt <= x_cnt + LEN_ONE;
      end
    end
  end

  // R4: the word index never leaves the programmed line
  p_x_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (x_cnt < len_q));

  // R6: the line index never passes the programmed count
  p_y_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (y_cnt <= lines_q));

  // R5: a line change moves the line base by exactly one stride
  p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && flags.line_end) |=>
      (line_base == $past(line_base) + ADDR_W'(stride_q)));

endmodule

// File: rtl/dma2d_ring_walk.sv
module dma2d_ring_walk
  import dma2d_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             active,
  input  logic [LEN_W-1:0] ld_stride,
  input  logic [CNT_W-1:0] ld_lines,
  output ring_flags_t      flags
);

  localparam int PW = LEN_W + CNT_W + 1;
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [PW-1:0] region;
  logic [PW-1:0] last_q;
  logic [PW-1:0] half_last_q;
  logic [PW-1:0] pos;

  assign region         = PW'(ld_stride) * (PW'(ld_lines) + P_ONE);
  assign flags.half_end = (pos == half_last_q);
  assign flags.wrap     = (pos == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q      <= '0;
      half_last_q <= '0;
      pos         <= '0;
    end else if (load) begin
      last_q      <= region - P_ONE;
      half_last_q <= (region >> 1) - P_ONE;
      pos         <= '0;
    end else if (step) begin
      pos <= flags.wrap ? '0 : pos + P_ONE;
    end
  end

  // R7: the ring offset stays inside the region
  p_pos_in_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pos <= last_q));

  // R8: the two half marks are distinct points of the ring
  p_half_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $onehot0({flags.half_end, flags.wrap}));

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [LEN_W-1:0]  cfg_stride,
  input  logic [CNT_W-1:0]  cfg_line_cnt,
  input  logic              cfg_dir,
  input  logic              cfg_burst,
  input  logic              loop_en,
  input  logic              start,
  input  logic              invalidate,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              mem_read,
  output logic              burst4,
  output logic              done,
  output logic              half_a,
  output logic              half_b
);

  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  ch_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] ring_base_q;
  logic              dir_q;
  logic              burst_q;
  logic              done_q;
  logic              half_a_q;
  logic              half_b_q;

  logic              fire;
  logic              launch;
  logic              in_frame;
  logic              in_ring;
  line_flags_t       lflags;
  ring_flags_t       rflags;
  logic [ADDR_W-1:0] next_line_addr;

  assign fire     = req_valid && req_ready;
  assign launch   = start && (state == CH_IDLE) && !invalidate;
  assign in_frame = (state == CH_FRAME);
  assign in_ring  = (state == CH_RING);

  dma2d_line_walk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_line (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (launch),
    .step           (fire && in_frame && !invalidate),
    .active         (in_frame),
    .ld_addr        (cfg_start_addr),
    .ld_len         (cfg_line_len),
    .ld_stride      (cfg_stride),
    .ld_lines       (cfg_line_cnt),
    .flags          (lflags),
    .next_line_addr (next_line_addr)
  );

  dma2d_ring_walk #(
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .step      (fire && in_ring && !invalidate),
    .active    (in_ring),
    .ld_stride (cfg_stride),
    .ld_lines  (cfg_line_cnt),
    .flags     (rflags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= CH_IDLE;
      addr_q      <= '0;
      ring_base_q <= '0;
      dir_q       <= 1'b0;
      burst_q     <= 1'b0;
      done_q      <= 1'b0;
      half_a_q    <= 1'b0;
      half_b_q    <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      half_a_q <= 1'b0;
      half_b_q <= 1'b0;
      if (invalidate) begin
        state <= CH_IDLE;
      end else begin
        unique case (state)
          CH_IDLE: begin
            if (start) begin
              addr_q      <= cfg_start_addr;
              ring_base_q <= cfg_start_addr;
              dir_q       <= cfg_dir;
              burst_q     <= cfg_burst;
              state       <= (cfg_line_len == '0) ? CH_RING : CH_FRAME;
            end
          end
          CH_FRAME: begin
            if (fire) begin
              if (!lflags.line_end) begin
                addr_q <= addr_q + A_ONE;
              end else if (!lflags.frame_end) begin
                addr_q <= next_line_addr;
              end else begin
                done_q <= 1'b1;
                state  <= CH_IDLE;
              end
            end
          end
          CH_RING: begin
            if (fire) begin
              half_a_q <= rflags.half_end;
              half_b_q <= rflags.wrap;
              addr_q   <= rflags.wrap ? ring_base_q : addr_q + A_ONE;
              if (!loop_en) state <= CH_IDLE;
            end
          end
          default: state <= CH_IDLE;
        endcase
      end
    end
  end

  assign req_valid = (state != CH_IDLE);
  assign req_addr  = addr_q;
  assign mem_read  = dir_q;
  assign burst4    = burst_q;
  assign done      = done_q;
  assign half_a    = half_a_q;
  assign half_b    = half_b_q;

  // R3: an offered address is held until accepted
  p_hold_offer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !invalidate) |=> (req_valid && $stable(req_addr)));

  // R6: done is a single-cycle pulse and coincides with idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R7: a wrap returns the address to the ring start
  p_ring_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ring && fire && rflags.wrap && !invalidate) |=> (req_addr == ring_base_q));

  // R8: half events never coincide
  p_half_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({half_a, half_b, done}));

  // R10: direction and burst are constant across a running transfer
  p_mode_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!req_valid || ($stable(mem_read) && $stable(burst4))));

  // R11: abort leaves the channel idle and silent
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> (!req_valid && !done && !half_a && !half_b));

endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;

  localparam int AW = 30;
  localparam int LW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cfg_start_addr;
  logic [LW-1:0] cfg_line_len;
  logic [LW-1:0] cfg_stride;
  logic [CW-1:0] cfg_line_cnt;
  logic          cfg_dir, cfg_burst, loop_en, start, invalidate;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic          mem_read, burst4, done, half_a, half_b;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_addr(cfg_start_addr), .cfg_line_len(cfg_line_len),
    .cfg_stride(cfg_stride), .cfg_line_cnt(cfg_line_cnt),
    .cfg_dir(cfg_dir), .cfg_burst(cfg_burst), .loop_en(loop_en),
    .start(start), .invalidate(invalidate),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_read(mem_read), .burst4(burst4), .done(done),
    .half_a(half_a), .half_b(half_b)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [AW-1:0] sa, input int len, input int stride,
                        input int cnt, input logic dir, input logic burst);
    cfg_start_addr = sa;
    cfg_line_len   = LW'(len);
    cfg_stride     = LW'(stride);
    cfg_line_cnt   = CW'(cnt);
    cfg_dir        = dir;
    cfg_burst      = burst;
    start          = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R2 R3 R4 R5 R6: one frame, optional stalls every 'stall' cycles
  task automatic t_frame(input logic [AW-1:0] sa, input int len, input int stride,
                         input int cnt, input int stall);
    int total;
    int k;
    int cyc;
    logic [AW-1:0] e;
    logic [AW-1:0] last;
    string tag;
    total = len * (cnt + 1);
    k = 0;
    cyc = 0;
    last = sa + AW'(cnt * stride + len - 1);
    launch(sa, len, stride, cnt, 1'b0, 1'b0);
    chk("R10", "mem_read", mem_read, 0);
    while (k < total && cyc < 5000) begin
      e = sa + AW'((k / len) * stride + (k % len));
      if (k == 0) tag = "R2";
      else if (!req_ready) tag = "R3";
      else if ((k % len) == 0) tag = "R5";
      else tag = "R4";
      chk(tag, "req_valid", req_valid, 1);
      chk(tag, "req_addr", req_addr, e);
      chk("R6", "done early", done, 0);
      req_ready = (stall == 0) || ((cyc % stall) != 0);
      if (req_ready) k++;
      cyc++;
      @(negedge clk);
    end
    req_ready = 1'b0;
    chk("R6", "done", done, 1);
    chk("R6", "idle after done", req_valid, 0);
    chk("R6", "final addr held", req_addr, last);
    @(negedge clk);
    chk("R6", "done one cycle", done, 0);
    chk("R6", "final addr still held", req_addr, last);
  endtask

  // R7 R8 R9: ring mode for nwords accepted words, then loop_en cleared
  task automatic t_ring(input logic [AW-1:0] sa, input int stride, input int cnt,
                        input int nwords);
    int size;
    int prev;
    size = stride * (cnt + 1);
    loop_en = 1'b1;
    launch(sa, 0, stride, cnt, 1'b1, 1'b0);
    req_ready = 1'b1;
    for (int k = 0; k < nwords; k++) begin
      chk("R7", "ring valid", req_valid, 1);
      chk("R7", "ring addr", req_addr, sa + AW'(k % size));
      if (k > 0) begin
        prev = (k - 1) % size;
        chk("R8", "half_a", half_a, (prev == size / 2 - 1));
        chk("R8", "half_b", half_b, (prev == size - 1));
      end
      if (k == nwords - 1) loop_en = 1'b0;
      @(negedge clk);
    end
    prev = (nwords - 1) % size;
    chk("R8", "last half_b", half_b, (prev == size - 1));
    chk("R9", "ring stopped", req_valid, 0);
    chk("R9", "no done in ring", done, 0);
    req_ready = 1'b0;
    loop_en = 1'b1;
    @(negedge clk);
    chk("R9", "stays idle", req_valid, 0);
  endtask

  // R11: abort mid-frame, then start blocked by a simultaneous invalidate
  task automatic t_abort();
    launch(30'h500, 4, 4, 3, 1'b0, 1'b0);
    req_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "running before abort", req_valid, 1);
    invalidate = 1'b1;
    cfg_start_addr = 30'h600;
    start = 1'b1;
    @(negedge clk);
    chk("R11", "idle after abort", req_valid, 0);
    chk("R11", "no done on abort", done, 0);
    @(negedge clk);
    chk("R11", "start blocked by invalidate", req_valid, 0);
    invalidate = 1'b0;
    start = 1'b0;
    req_ready = 1'b0;
    @(negedge clk);
    chk("R11", "still idle", req_valid, 0);
  endtask

  // R2 R10: start while busy is ignored and mode bits stay latched
  task automatic t_busy_start();
    launch(30'h700, 2, 2, 1, 1'b1, 1'b1);
    req_ready = 1'b0;
    chk("R10", "mem_read latched", mem_read, 1);
    chk("R10", "burst4 latched", burst4, 1);
    cfg_start_addr = 30'h900;
    cfg_dir = 1'b0;
    cfg_burst = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy start ignored", req_addr, 30'h700);
    chk("R10", "mem_read stable", mem_read, 1);
    chk("R10", "burst4 stable", burst4, 1);
    req_ready = 1'b1;
    @(negedge clk);
    chk("R4", "advance after stall", req_addr, 30'h701);
    req_ready = 1'b0;
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    chk("R11", "cleanup idle", req_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_start_addr = '0;
    cfg_line_len = '0;
    cfg_stride = '0;
    cfg_line_cnt = '0;
    cfg_dir = 1'b0;
    cfg_burst = 1'b0;
    loop_en = 1'b1;
    start = 1'b0;
    invalidate = 1'b0;
    req_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", req_valid, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset half_a", half_a, 0);
    chk("R1", "reset half_b", half_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", req_valid, 0);

    t_frame(30'h100, 3, 5, 2, 0);
    t_frame(30'h2000, 4, 4, 0, 0);
    t_frame(30'h300, 2, 7, 3, 3);
    t_frame(30'h3FFF0, 1, 1, 4, 2);
    t_ring(30'h40, 2, 3, 16);
    t_ring(30'h80, 1, 1, 5);
    t_ring(30'hC0, 4, 1, 3);
    t_abort();
    t_busy_start();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule